// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block decides which of eight interrupt lines should be presented to the processor. It ranks the lines by a rotating priority: a programmable base line is the most important, and importance falls off line by line upward from the base, wrapping around. A line is a candidate when it is requesting and not masked. The request output is raised only if the best candidate strictly outranks the best line already in service. When the processor acknowledges, the block moves the winning line into service and returns an interrupt vector. It also tells the request-capture logic to drop the request if the line is edge-triggered.

The block also carries out end-of-interrupt and priority commands. Each command arrives as a single-cycle decoded strobe. Other supported features are automatic end-of-interrupt (optionally rotating), a nested mode on the primary controller that lets a cascaded secondary interrupt again while it is in service, and a spurious vector when an acknowledge finds nothing pending. Request capture and register programming are done outside this block. Mask, trigger mode and configuration arrive as plain inputs.

Top module: `rpr_resolver`

## Requirements
- R1: With base b, line i has level (i - b) mod 8, and level 0 is the highest. The winner is the candidate with the lowest level. An empty set has level 8.
- R2: The candidates are req_in AND NOT mask_in. irq_out is a register. It goes high one clock after a cycle in which the best candidate's level is strictly below the in-service level, and it is low after reset. After reset, the base is 0 and no line is in service.
- R3: When nested_en is set (primary instance), in-service bit 2 is left out when the in-service level is computed. This lets line 2 win again while it is already in service.
- R4: An acknowledge with a pending winner w returns vector = {vec_base, w}. The acknowledge sets in-service bit w at the next edge. It pulses req_clr[w] in the same cycle only if trig_level[w] is 0 (edge-triggered).
- R5: When auto_eoi is set, an acknowledge leaves in-service unchanged. If rot_auto_eoi is also set, the base becomes (w + 1) mod 8.
- R6: An acknowledge with nothing pending returns vector = {vec_base, 3'd7}. It changes no in-service bit and pulses no req_clr bit.
- R7: cmd_eoi with cmd_specific low clears the highest-priority in-service bit (the raw in-service set, no nested exclusion). If cmd_rotate is also set, the base becomes that line + 1. The command has no effect when nothing is in service.
- R8: cmd_eoi with cmd_specific high clears in-service bit cmd_line. If cmd_rotate is also set, the base becomes cmd_line + 1.
- R9: cmd_setprio, when cmd_eoi is low, sets the base to (cmd_line + 1) mod 8.
- R10: If an acknowledge and a command fall in the same cycle, the command's clear acts on the in-service set as it was before the acknowledge, and the acknowledge's set bit is applied after it. A base change from the command takes precedence over an auto-EOI rotation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_in | input | 8 | Captured request bits |
| mask_in | input | 8 | Mask bits, 1 = line masked |
| trig_level | input | 8 | Trigger mode per line, 1 = level, 0 = edge |
| auto_eoi | input | 1 | Automatic end-of-interrupt enable |
| rot_auto_eoi | input | 1 | Rotate base on automatic end-of-interrupt |
| nested_en | input | 1 | Nested mode: ignore in-service bit 2 for the current level |
| vec_base | input | 5 | Upper five bits of the returned vector |
| ack | input | 1 | Single-cycle acknowledge strobe |
| cmd_eoi | input | 1 | End-of-interrupt strobe |
| cmd_specific | input | 1 | Qualifies cmd_eoi: clear cmd_line instead of the highest line |
| cmd_rotate | input | 1 | Qualifies cmd_eoi: rotate base past the cleared line |
| cmd_setprio | input | 1 | Set-base strobe |
| cmd_line | input | 3 | Line operand for commands |
| vector | output | 8 | Interrupt vector, valid in the acknowledge cycle |
| req_clr | output | 8 | One-cycle clear pulse to the request capture |
| irq_out | output | 1 | Registered interrupt request |
| in_service | output | 8 | In-service bits |

## Verification
The acknowledge and an end-of-interrupt or set-base command can fall in the same clock cycle, and they compete for both the in-service set and the base. The bench provokes this in two ways. First, it strobes ack together with a non-specific EOI while a line is already in service. Second, it strobes ack under rotating auto-EOI together with a set-base command. A bench model that applies the command to the in-service set before the acknowledge, and lets the command's base win, predicts the in-service set, the vector and the following priority order. The bench compares these predictions with the ports.

// File: rtl/rpr_pkg.sv
package rpr_pkg;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_EOI_TOP,
    OP_EOI_TOP_ROT,
    OP_EOI_LINE,
    OP_EOI_LINE_ROT,
    OP_SET_BASE
  } rpr_op_e;

  function automatic rpr_op_e rpr_decode(input logic eoi, input logic specific,
                                         input logic rotate, input logic setprio);
    rpr_op_e op;
    op = OP_IDLE;
    if (eoi) begin
      if (specific) op = rotate ? OP_EOI_LINE_ROT : OP_EOI_LINE;
      else          op = rotate ? OP_EOI_TOP_ROT  : OP_EOI_TOP;
    end else if (setprio) begin
      op = OP_SET_BASE;
    end
    return op;
  endfunction

endpackage

// File: rtl/rpr_rank.sv
module rpr_rank #(
  parameter int N  = 8,
  localparam int LW = $clog2(N)
) (
  input  logic [N-1:0]  set_in,
  input  logic [LW-1:0] base,
  output logic [LW:0]   level
);
  always_comb begin
    logic found;
    logic [LW-1:0] idx;
    found = 1'b0;
    level = LW'(0) + (LW+1)'(N);
    for (int k = 0; k < N; k++) begin
      idx = base + LW'(k);
      if (!found && set_in[idx]) begin
        found = 1'b1;
        level = (LW+1)'(k);
      end
    end
  end
endmodule

// File: rtl/rpr_arbiter.sv
module rpr_arbiter #(
  parameter int N       = 8,
  parameter int CASCADE = 2,
  parameter bit PRIMARY = 1'b1,
  localparam int LW = $clog2(N)
) (
  input  logic [N-1:0]  req_in,
  input  logic [N-1:0]  mask_in,
  input  logic [N-1:0]  isr_q,
  input  logic [LW-1:0] base_q,
  input  logic          nested_en,
  output logic          pend,
  output logic [LW-1:0] win_line
);
  logic [N-1:0] cand;
  logic [N-1:0] isr_eff;
  logic [LW:0]  cand_lvl;
  logic [LW:0]  isr_lvl;

  assign cand = req_in & ~mask_in;

  generate
    if (PRIMARY) begin : g_primary
      always_comb begin
        isr_eff = isr_q;
        if (nested_en) isr_eff[CASCADE] = 1'b0;
      end
    end else begin : g_secondary
      logic unused_nested;
      assign unused_nested = nested_en;
      assign isr_eff = isr_q;
    end
  endgenerate

  rpr_rank #(.N(N)) u_cand_rank (.set_in(cand),    .base(base_q), .level(cand_lvl));
  rpr_rank #(.N(N)) u_isr_rank  (.set_in(isr_eff), .base(base_q), .level(isr_lvl));

  assign pend     = (cand_lvl < isr_lvl);
  assign win_line = base_q + cand_lvl[LW-1:0];
endmodule

// File: rtl/rpr_service.sv
module rpr_service #(
  parameter int N = 8,
  localparam int LW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ack_hit,
  input  logic [LW-1:0] win_line,
  input  logic          auto_eoi,
  input  logic          rot_auto_eoi,
  input  logic          cmd_eoi,
  input  logic          cmd_specific,
  input  logic          cmd_rotate,
  input  logic          cmd_setprio,
  input  logic [LW-1:0] cmd_line,
  output logic [N-1:0]  isr_q,
  output logic [LW-1:0] base_q
);
  import rpr_pkg::*;

  rpr_op_e       op;
  logic [LW:0]   top_lvl;
  logic [LW-1:0] top_line;
  logic [N-1:0]  clr_m, set_m, isr_d;
  logic [LW-1:0] base_d;
  logic          cmd_base_we;
  logic          isr_en, base_en;

  rpr_rank #(.N(N)) u_top_rank (.set_in(isr_q), .base(base_q), .level(top_lvl));
  assign top_line = base_q + top_lvl[LW-1:0];

  always_comb begin
    op          = rpr_decode(cmd_eoi, cmd_specific, cmd_rotate, cmd_setprio);
    clr_m       = '0;
    set_m       = '0;
    base_d      = base_q;
    cmd_base_we = 1'b0;
    case (op)
      OP_EOI_TOP, OP_EOI_TOP_ROT: begin
        if (top_lvl != (LW+1)'(N)) begin
          clr_m[top_line] = 1'b1;
          if (op == OP_EOI_TOP_ROT) begin
            base_d      = top_line + 1'b1;
            cmd_base_we = 1'b1;
          end
        end
      end
      OP_EOI_LINE, OP_EOI_LINE_ROT: begin
        clr_m[cmd_line] = 1'b1;
        if (op == OP_EOI_LINE_ROT) begin
          base_d      = cmd_line + 1'b1;
          cmd_base_we = 1'b1;
        end
      end
      OP_SET_BASE: begin
        base_d      = cmd_line + 1'b1;
        cmd_base_we = 1'b1;
      end
      default: ;
    endcase
    if (ack_hit && !auto_eoi) set_m[win_line] = 1'b1;
    if (ack_hit && auto_eoi && rot_auto_eoi && !cmd_base_we)
      base_d = win_line + 1'b1;
    isr_d   = (isr_q & ~clr_m) | set_m;
    isr_en  = ack_hit || (op != OP_IDLE);
    base_en = cmd_base_we || (ack_hit && auto_eoi && rot_auto_eoi);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q  <= '0;
      base_q <= '0;
    end else begin
      if (isr_en)  isr_q  <= isr_d;
      if (base_en) base_q <= base_d;
    end
  end

  assert_ack_sets_isr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit && !auto_eoi) |=> isr_q[$past(win_line)]);

  assert_auto_eoi_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit && auto_eoi && !cmd_eoi) |=> (isr_q == $past(isr_q)));

  assert_eoi_empty_noop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_eoi && !cmd_specific && isr_q == '0 && !ack_hit) |=> (isr_q == '0));

  assert_specific_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_eoi && cmd_specific && !(ack_hit && !auto_eoi && win_line == cmd_line))
      |=> !isr_q[$past(cmd_line)]);

  assert_set_base_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_setprio && !cmd_eoi) |=> (base_q == $past(cmd_line) + 1'b1));
endmodule

// File: rtl/rpr_resolver.sv
module rpr_resolver #(
  parameter int N       = 8,
  parameter int VEC_W   = 8,
  parameter int CASCADE = 2,
  parameter bit PRIMARY = 1'b1,
  localparam int LW = $clog2(N),
  localparam int BW = VEC_W - LW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_in,
  input  logic [N-1:0]  mask_in,
  input  logic [N-1:0]  trig_level,
  input  logic          auto_eoi,
  input  logic          rot_auto_eoi,
  input  logic          nested_en,
  input  logic [BW-1:0] vec_base,
  input  logic          ack,
  input  logic          cmd_eoi,
  input  logic          cmd_specific,
  input  logic          cmd_rotate,
  input  logic          cmd_setprio,
  input  logic [LW-1:0] cmd_line,
  output logic [VEC_W-1:0] vector,
  output logic [N-1:0]  req_clr,
  output logic          irq_out,
  output logic [N-1:0]  in_service
);
  logic          rs_meta, rs_sync;
  logic          pend;
  logic [LW-1:0] win_line;
  logic [N-1:0]  isr_q;
  logic [LW-1:0] base_q;
  logic          ack_hit;
  logic          irq_q;
  logic [LW-1:0] out_line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_sync <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_sync <= rs_meta;
    end
  end

  rpr_arbiter #(.N(N), .CASCADE(CASCADE), .PRIMARY(PRIMARY)) u_arb (
    .req_in(req_in), .mask_in(mask_in), .isr_q(isr_q), .base_q(base_q),
    .nested_en(nested_en), .pend(pend), .win_line(win_line));

  assign ack_hit = ack && pend;

  rpr_service #(.N(N)) u_svc (
    .clk(clk), .rst_n(rs_sync), .ack_hit(ack_hit), .win_line(win_line),
    .auto_eoi(auto_eoi), .rot_auto_eoi(rot_auto_eoi), .cmd_eoi(cmd_eoi),
    .cmd_specific(cmd_specific), .cmd_rotate(cmd_rotate),
    .cmd_setprio(cmd_setprio), .cmd_line(cmd_line),
    .isr_q(isr_q), .base_q(base_q));

  always_ff @(posedge clk or negedge rs_sync) begin
    if (!rs_sync) irq_q <= 1'b0;
    else          irq_q <= pend;
  end

  always_comb begin
    out_line = pend ? win_line : LW'(N - 1);
    req_clr  = '0;
    if (ack_hit && !trig_level[win_line]) req_clr[win_line] = 1'b1;
  end

  assign vector     = {vec_base, out_line};
  assign irq_out    = irq_q;
  assign in_service = isr_q;

  assert_irq_needs_cand_R2: assert property (@(posedge clk) disable iff (!rs_sync)
    irq_out |-> $past((req_in & ~mask_in) != '0));

  assert_clr_edge_only_R4: assert property (@(posedge clk) disable iff (!rs_sync)
    ((req_clr & trig_level) == '0) && $onehot0(req_clr));

  assert_spurious_R6: assert property (@(posedge clk) disable iff (!rs_sync)
    (ack && !pend) |-> (vector[LW-1:0] == LW'(N - 1) && req_clr == '0));
endmodule

// File: tb/rpr_resolver_test.sv
module rpr_resolver_test;
  logic clk = 1'b0;
  logic rst_n;
  logic [7:0] req_in, mask_in, trig_level, in_service, req_clr, vector;
  logic auto_eoi, rot_auto_eoi, nested_en, ack, cmd_eoi, cmd_specific;
  logic cmd_rotate, cmd_setprio, irq_out;
  logic [4:0] vec_base;
  logic [2:0] cmd_line;

  always #10 clk = ~clk;

  rpr_resolver uut (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .mask_in(mask_in),
    .trig_level(trig_level), .auto_eoi(auto_eoi), .rot_auto_eoi(rot_auto_eoi),
    .nested_en(nested_en), .vec_base(vec_base), .ack(ack), .cmd_eoi(cmd_eoi),
    .cmd_specific(cmd_specific), .cmd_rotate(cmd_rotate),
    .cmd_setprio(cmd_setprio), .cmd_line(cmd_line), .vector(vector),
    .req_clr(req_clr), .irq_out(irq_out), .in_service(in_service));

  typedef struct {
    string      tag;
    logic [7:0] vec;
    logic [7:0] clr;
    logic [7:0] isr;
    logic       irq;
  } exp_t;

  exp_t sb_q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // model state
  logic [7:0] m_req = 0, m_isr = 0, m_mask = 0, m_lvl = 0;
  logic [2:0] m_base = 0;
  logic m_int = 0;
  logic t_ack = 0, t_eoi = 0, t_spec = 0, t_rot = 0, t_setp = 0;
  logic t_auto = 0, t_rauto = 0, t_nest = 0;
  logic [2:0] t_line = 0;
  logic [4:0] t_vb = 5'h15;

  function automatic int lvl_of(logic [7:0] s, logic [2:0] b);
    for (int k = 0; k < 8; k++) if (s[3'(b + 3'(k))]) return k;
    return 8;
  endfunction

  task automatic step(string tag);
    exp_t e;
    logic [7:0] cand, iv, clrm, setm, eclr;
    logic [2:0] win, nb, tgt;
    logic pend, bwe;
    int cl, il, hl;
    @(negedge clk);
    req_in = m_req; mask_in = m_mask; trig_level = m_lvl;
    auto_eoi = t_auto; rot_auto_eoi = t_rauto; nested_en = t_nest;
    vec_base = t_vb; ack = t_ack; cmd_eoi = t_eoi; cmd_specific = t_spec;
    cmd_rotate = t_rot; cmd_setprio = t_setp; cmd_line = t_line;
    cand = m_req & ~m_mask;
    iv = m_isr; if (t_nest) iv[2] = 1'b0;
    cl = lvl_of(cand, m_base); il = lvl_of(iv, m_base);
    pend = cl < il;
    win = m_base + 3'(cl);
    eclr = (t_ack && pend && !m_lvl[win]) ? (8'h1 << win) : 8'h0;
    e.tag = tag; e.vec = {t_vb, pend ? win : 3'd7}; e.clr = eclr;
    e.isr = m_isr; e.irq = m_int;
    sb_q.push_back(e);
    clrm = 0; setm = 0; nb = m_base; bwe = 0;
    if (t_eoi) begin
      if (t_spec) begin
        clrm = 8'h1 << t_line;
        if (t_rot) begin nb = t_line + 3'd1; bwe = 1; end
      end else begin
        hl = lvl_of(m_isr, m_base);
        if (hl < 8) begin
          tgt = m_base + 3'(hl); clrm = 8'h1 << tgt;
          if (t_rot) begin nb = tgt + 3'd1; bwe = 1; end
        end
      end
    end else if (t_setp) begin
      nb = t_line + 3'd1; bwe = 1;
    end
    if (t_ack && pend && !t_auto) setm = 8'h1 << win;
    if (t_ack && pend && t_auto && t_rauto && !bwe) nb = win + 3'd1;
    m_isr = (m_isr & ~clrm) | setm;
    m_base = nb; m_int = pend; m_req = m_req & ~eclr;
    t_ack = 0; t_eoi = 0; t_spec = 0; t_rot = 0; t_setp = 0;
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic do_ack(string tag);
    t_ack = 1; step(tag);
  endtask

  task automatic do_eoi(bit spec, bit rot, logic [2:0] ln, string tag);
    t_eoi = 1; t_spec = spec; t_rot = rot; t_line = ln; step(tag);
  endtask

  // monitor: pop and compare
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_cmp++;
        if (vector !== e.vec || req_clr !== e.clr || in_service !== e.isr || irq_out !== e.irq) begin
          n_bad++;
          $display("FAIL %s: vec=%h clr=%h isr=%h irq=%b expected vec=%h clr=%h isr=%h irq=%b",
                   e.tag, vector, req_clr, in_service, irq_out, e.vec, e.clr, e.isr, e.irq);
        end
      end
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req_in = 0; mask_in = 0; trig_level = 0; auto_eoi = 0;
    rot_auto_eoi = 0; nested_en = 0; vec_base = 0; ack = 0; cmd_eoi = 0;
    cmd_specific = 0; cmd_rotate = 0; cmd_setprio = 0; cmd_line = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    idle(3, "R2 reset state");
    // R1/R2/R4: single edge request then acknowledge
    m_req = 8'h08; idle(2, "R2 raise");
    do_ack("R4 ack line3"); idle(2, "R4 after ack");
    // R2: lower priority blocked, higher passes
    m_req |= 8'h20; idle(2, "R2 lower blocked");
    m_req |= 8'h02; idle(2, "R2 higher pending");
    do_ack("R1 ack line1"); idle(1, "R4 isr two");
    do_eoi(0, 0, 0, "R7 ns eoi"); do_eoi(0, 0, 0, "R7 ns eoi second");
    m_mask = 8'h20; idle(2, "R2 masked");
    m_mask = 8'h00; idle(2, "R2 unmasked");
    // R4: level line keeps its request
    m_lvl = 8'h20; do_ack("R4 level no clear"); idle(1, "R4 level");
    do_eoi(1, 0, 3'd5, "R8 specific eoi"); m_req = 0; m_lvl = 0;
    idle(2, "R8 after");
    // R1/R7/R8 rotation
    m_req = 8'h81; idle(2, "R1 setup");
    do_ack("R1 ack line0"); idle(1, "R1 line7 blocked");
    do_eoi(0, 1, 0, "R7 rotating eoi"); m_req |= 8'h04; idle(2, "R1 base1");
    do_ack("R1 ack line2 over 7");
    do_eoi(1, 1, 3'd2, "R8 specific rotate"); m_req |= 8'h02; idle(2, "R1 base3");
    do_ack("R1 ack line7 over 1"); do_eoi(0, 0, 0, "R7 clear"); idle(1, "R7");
    do_ack("R1 ack line1"); do_eoi(0, 0, 0, "R7 clear"); idle(1, "R7");
    // R9: set priority
    t_setp = 1; t_line = 3'd6; step("R9 set base");
    m_req = 8'h41; idle(2, "R9 setup");
    do_ack("R9 line0 wins"); do_eoi(0, 0, 0, "R7"); idle(1, "R9");
    do_ack("R9 line6"); do_eoi(0, 0, 0, "R7"); idle(1, "R9");
    do_eoi(0, 0, 0, "R7 empty eoi no effect"); idle(1, "R7 empty");
    // R5: automatic EOI with rotation
    t_auto = 1; t_rauto = 1; m_req = 8'h18; idle(2, "R5 setup");
    do_ack("R5 auto ack"); idle(1, "R5 isr untouched");
    do_ack("R5 auto ack second"); idle(2, "R5 after");
    t_auto = 0; t_rauto = 0;
    // R3: nested mode on cascade line
    m_req = 8'h04; idle(2, "R3 setup"); do_ack("R3 ack line2");
    m_req = 8'h04; idle(2, "R3 blocked without nested");
    t_nest = 1; idle(2, "R3 nested pending");
    do_ack("R3 nested ack"); t_nest = 0;
    do_eoi(1, 0, 3'd2, "R8 clear line2"); idle(2, "R3 end");
    // R6: spurious
    m_req = 0; idle(2, "R6 setup"); do_ack("R6 spurious"); idle(1, "R6 after");
    // R10: collisions
    m_req = 8'h02; idle(2, "R10 setup"); do_ack("R10 first ack");
    m_req = 8'h01; idle(2, "R10 setup2");
    t_eoi = 1; t_ack = 1; step("R10 ack with ns eoi"); idle(2, "R10 after");
    t_auto = 1; t_rauto = 1; m_req = 8'h30; idle(2, "R10 setup3");
    t_ack = 1; t_setp = 1; t_line = 3'd1; step("R10 ack with set base");
    idle(2, "R10 base check"); t_ack = 1; step("R10 order check");
    t_auto = 0; t_rauto = 0;
    do_eoi(0, 0, 0, "R7 cleanup"); idle(3, "R10 end");
    @(negedge clk); #6;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule